// File: doc/BRIEF.md
# DDR Write Data Rate Adapter

This block sits between a wide local write port and a narrow DDR data path. It takes one local word per cycle, together with its active-high byte-enable vector and a word address. It then plays that word out as a burst of narrow memory beats, one per cycle. Each beat carries its DQ slice and an active-low DM slice. The parameter `HALF_RATE` sets the width ratio. With `HALF_RATE` = 0 (full rate), the local word is twice the memory width and yields two beats. With `HALF_RATE` = 1 (half rate), the local word is four times the memory width and yields four beats.

The block also splits the local address into the memory row, bank and column. The local address does not carry the low column bits that select a beat inside the burst (one bit at full rate, two at half rate). The adapter puts them back as zeros.

The local side uses a valid/ready handshake. The ready signal is held low only while the non-final beats of the current word are still being sent. The next word is therefore taken on the final beat, and back-to-back words leave without an idle cycle between them.

Top module: `ddr_wdata_adapter`

## Requirements
- R1: With `HALF_RATE` = 0, each accepted local word produces exactly two consecutive beats with `out_valid` high. The first beat appears in the cycle after the acceptance edge.
- R2: With `HALF_RATE` = 1, each accepted local word produces exactly four consecutive beats with `out_valid` high. The first beat appears in the cycle after the acceptance edge.
- R3: Beat i of a word drives `out_dq` = `in_data[i*MEM_DW +: MEM_DW]`, so the least significant slice goes first.
- R4: Beat i drives `out_dm[j]` = NOT `in_be[i*(MEM_DW/8) + j]`. A mask bit of 1 blocks that byte lane.
- R5: With `HALF_RATE` = 0 and the default geometry (24-bit address), the outputs are: `out_row` = addr[23:11], `out_bank` = addr[10:9], `out_col` = {addr[8:0], 1'b0}.
- R6: With `HALF_RATE` = 1 and the default geometry (23-bit address), the outputs are: `out_row` = addr[22:10], `out_bank` = addr[9:8], `out_col` = {addr[7:0], 2'b00}.
- R7: `in_ready` is high when the block is idle or on the final beat of a word, and low on every other beat. A word offered on a final beat is sent starting in the next cycle, with no idle cycle in between.
- R8: `out_row`, `out_bank` and `out_col` hold the same value on every beat of one word.
- R9: Reset is synchronous and active low. While in reset, and whenever no beat is valid, `out_valid` is 0, `out_dq` is 0 and every `out_dm` bit is 1. A reset that arrives mid-word discards the rest of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Local word offered |
| in_ready | output | 1 | Local word taken at this edge if valid |
| in_addr | input | ROW_W+BANK_W+COL_W-log2(RATIO) | Local word address |
| in_data | input | MEM_DW*RATIO | Local write data |
| in_be | input | MEM_DW*RATIO/8 | Byte enables, active high |
| out_valid | output | 1 | Memory beat valid |
| out_dq | output | MEM_DW | Beat data |
| out_dm | output | MEM_DW/8 | Beat data mask, active low (1 = blocked) |
| out_row | output | ROW_W | Row address |
| out_bank | output | BANK_W | Bank address |
| out_col | output | COL_W | Column address with zeroed low bits |

## Verification
Two things can happen in the same cycle: the final beat of one word is emitted, and the next word is accepted. Both converge on the beat counter and the holding register. The bench offers words on almost every cycle, so this overlap happens hundreds of times in each mode. Sparse gaps and one stretch of widely spaced words are mixed in. For every overlap, the bench checks three things at the next cycle: the output is beat 0 of the new word, the mask comes from the new byte enables, and the address comes from the new word. A reset is also applied in the middle of a word to show that the rest of the word is dropped.

// File: rtl/ddr_wr_pkg.sv
// Package ddr_wr_pkg
// Shared helper for the DDR write data rate adapter.
// Assumes the memory beat count per local word is a power of two.
package ddr_wr_pkg;
    // Beats per local word for the selected rate mode
    function automatic int beats_per_word(input bit half_rate);
        return half_rate ? 4 : 2;
    endfunction
endpackage

// File: rtl/ddr_addr_split.sv
// Module ddr_addr_split
// Splits a local word address into row, bank and column fields.
// The column gets DROP zero bits appended at its low end.
// Assumes address layout {row, bank, column-high-bits}.
module ddr_addr_split #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10,
    parameter int DROP   = 1,
    localparam int COLH_W = COL_W - DROP,
    localparam int ADDR_W = ROW_W + BANK_W + COLH_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ROW_W-1:0]  row,
    output logic [BANK_W-1:0] bank,
    output logic [COL_W-1:0]  col
);
    // Field extraction; the low column bits are rebuilt as zeros
    always_comb begin
        row  = addr[ADDR_W-1 -: ROW_W];
        bank = addr[COLH_W +: BANK_W];
        col  = {addr[COLH_W-1:0], {DROP{1'b0}}};
    end
endmodule

// File: rtl/ddr_beat_ctrl.sv
// Module ddr_beat_ctrl
// Beat sequencer: tracks the beat counter and busy state, and produces the
// local-side ready and the load strobe. Ready is high when idle or on the
// final beat, so words stream back to back.
// Assumes RATIO is a power of two, 2 or greater.
module ddr_beat_ctrl #(
    parameter int RATIO = 2,
    localparam int IDX_W = $clog2(RATIO)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             load,
    output logic             busy,
    output logic [IDX_W-1:0] beat
);
    logic last;

    // Decode of the final beat and the handshake
    always_comb begin
        last     = busy && (beat == IDX_W'(RATIO - 1));
        in_ready = !busy || last;
        load     = in_valid && in_ready;
    end

    // Beat counter and busy flag, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (load) begin
            busy <= 1'b1;
            beat <= '0;
        end else if (last) begin
            busy <= 1'b0;
            beat <= '0;
        end else if (busy) begin
            beat <= beat + 1'b1;
        end
    end

    // R1 R2
    load_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (busy && beat == '0));

    // R1 R2
    beat_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !in_ready) |=> (busy && beat == $past(beat) + 1'b1));

    // R7
    ready_blocked_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat != IDX_W'(RATIO - 1)) |-> !in_ready);
endmodule

// File: rtl/ddr_lane_select.sv
// Module ddr_lane_select
// Picks the memory-width data slice and inverts the matching byte enables
// into an active-low mask for the current beat. Lowest slice is beat 0.
// While idle it drives zero data and an all-ones (blocking) mask.
module ddr_lane_select #(
    parameter int MEM_DW = 16,
    parameter int RATIO  = 2,
    localparam int MEM_DM = MEM_DW / 8,
    localparam int LOC_DW = MEM_DW * RATIO,
    localparam int LOC_BE = MEM_DM * RATIO,
    localparam int IDX_W  = $clog2(RATIO)
) (
    input  logic [LOC_DW-1:0] word,
    input  logic [LOC_BE-1:0] be,
    input  logic [IDX_W-1:0]  beat,
    input  logic              busy,
    output logic [MEM_DW-1:0] dq,
    output logic [MEM_DM-1:0] dm
);
    logic [MEM_DW-1:0] dq_lane [RATIO];
    logic [MEM_DM-1:0] dm_lane [RATIO];

    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign dq_lane[g] = word[g*MEM_DW +: MEM_DW];
        assign dm_lane[g] = ~be[g*MEM_DM +: MEM_DM];
    end

    // Beat multiplexer with idle masking
    always_comb begin
        dq = busy ? dq_lane[beat] : '0;
        dm = busy ? dm_lane[beat] : '1;
    end
endmodule

// File: rtl/ddr_wdata_adapter.sv
// Module ddr_wdata_adapter (top)
// DDR write data rate adapter. Holds each accepted local word and plays it
// out as RATIO memory beats, least significant slice first, with masks that
// are the inverse of the byte enables. The row, bank and column come from
// the held address and stay fixed for the whole word.
// Assumes MEM_DW is a multiple of 8. Reset is synchronous and active low.
module ddr_wdata_adapter #(
    parameter bit HALF_RATE = 1'b0,
    parameter int MEM_DW    = 16,
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 10,
    localparam int RATIO  = ddr_wr_pkg::beats_per_word(HALF_RATE),
    localparam int DROP   = $clog2(RATIO),
    localparam int MEM_DM = MEM_DW / 8,
    localparam int LOC_DW = MEM_DW * RATIO,
    localparam int LOC_BE = MEM_DM * RATIO,
    localparam int ADDR_W = ROW_W + BANK_W + COL_W - DROP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LOC_DW-1:0] in_data,
    input  logic [LOC_BE-1:0] in_be,
    output logic              out_valid,
    output logic [MEM_DW-1:0] out_dq,
    output logic [MEM_DM-1:0] out_dm,
    output logic [ROW_W-1:0]  out_row,
    output logic [BANK_W-1:0] out_bank,
    output logic [COL_W-1:0]  out_col
);
    localparam int IDX_W = $clog2(RATIO);

    logic              load;
    logic              busy;
    logic [IDX_W-1:0]  beat;
    logic [LOC_DW-1:0] hold_data;
    logic [LOC_BE-1:0] hold_be;
    logic [ADDR_W-1:0] hold_addr;

    ddr_beat_ctrl #(.RATIO(RATIO)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .busy     (busy),
        .beat     (beat)
    );

    // Holding register for the word being sent
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_be   <= '0;
            hold_addr <= '0;
        end else if (load) begin
            hold_data <= in_data;
            hold_be   <= in_be;
            hold_addr <= in_addr;
        end
    end

    ddr_lane_select #(.MEM_DW(MEM_DW), .RATIO(RATIO)) u_lanes (
        .word (hold_data),
        .be   (hold_be),
        .beat (beat),
        .busy (busy),
        .dq   (out_dq),
        .dm   (out_dm)
    );

    ddr_addr_split #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DROP(DROP)
    ) u_split (
        .addr (hold_addr),
        .row  (out_row),
        .bank (out_bank),
        .col  (out_col)
    );

    // Beat valid follows the sequencer's busy state
    always_comb out_valid = busy;

    // R3
    first_slice_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_dq == $past(in_data[MEM_DW-1:0])));

    // R4
    first_mask_inverted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (out_dm == ~$past(in_be[MEM_DM-1:0])));

    // R8
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_ready) |=> ($stable(out_row) && $stable(out_bank) && $stable(out_col)));

    // R9
    always_comb begin
        idle_mask_chk: assert (out_valid || (&out_dm && out_dq == '0));
    end
endmodule

// File: tb/ddr_wdata_adapter_bench.sv
// Driver and scoreboard for one rate mode. It generates words arithmetically
// and works out each expected beat from the requirements.
module ddr_wdata_adapter_drv #(
    parameter bit HALF = 1'b0
) (
    input  logic clk,
    output int   checks,
    output int   errors,
    output logic done
);
    localparam int RATIO  = HALF ? 4 : 2;
    localparam int LOC_DW = 16 * RATIO;
    localparam int LOC_BE = 2 * RATIO;
    localparam int ADDR_W = HALF ? 23 : 24;
    localparam int NWORDS = 256;

    logic              rst_n;
    logic              in_valid;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr;
    logic [LOC_DW-1:0] in_data;
    logic [LOC_BE-1:0] in_be;
    logic              out_valid;
    logic [15:0]       out_dq;
    logic [1:0]        out_dm;
    logic [12:0]       out_row;
    logic [1:0]        out_bank;
    logic [9:0]        out_col;

    ddr_wdata_adapter #(.HALF_RATE(HALF)) u_ddr_wdata_adapter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
        .out_valid(out_valid), .out_dq(out_dq), .out_dm(out_dm),
        .out_row(out_row), .out_bank(out_bank), .out_col(out_col)
    );

    function automatic logic [LOC_DW-1:0] gen_data(input int k);
        logic [LOC_DW-1:0] d;
        for (int j = 0; j < LOC_DW / 8; j++) d[8*j +: 8] = 8'(k * 37 + j * 11 + 5);
        return d;
    endfunction

    function automatic logic [LOC_BE-1:0] gen_be(input int k);
        return LOC_BE'(k);
    endfunction

    function automatic logic [ADDR_W-1:0] gen_addr(input int k);
        return ADDR_W'((k * 32'h9E3779B1) ^ (k << 5));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s half=%0d actual=%h expected=%h", tag, HALF, act, exp);
        end
    endtask

    // Compare the visible outputs with the expected beat b of word w
    task automatic check_beat(input int w, input int b);
        logic [LOC_DW-1:0] d;
        logic [LOC_BE-1:0] e;
        logic [ADDR_W-1:0] a;
        logic [12:0] er;
        logic [1:0]  eb;
        logic [9:0]  ec;
        d = gen_data(w);
        e = gen_be(w);
        a = gen_addr(w);
        if (HALF) begin
            er = a[22:10]; eb = a[9:8]; ec = {a[7:0], 2'b00};
        end else begin
            er = a[23:11]; eb = a[10:9]; ec = {a[8:0], 1'b0};
        end
        chk(out_valid == 1'b1, HALF ? "R2 beat valid" : "R1 beat valid",
            64'(out_valid), 64'd1);
        chk(out_dq == d[16*b +: 16], "R3 dq slice", 64'(out_dq), 64'(d[16*b +: 16]));
        chk(out_dm == ~e[2*b +: 2], "R4 dm mask", 64'(out_dm), 64'(~e[2*b +: 2]));
        chk(out_row == er && out_bank == eb && out_col == ec,
            HALF ? "R6 R8 row/bank/col" : "R5 R8 row/bank/col",
            {out_row, out_bank, out_col}, {er, eb, ec});
        chk(in_ready == (b == RATIO - 1), "R7 ready", 64'(in_ready), 64'(b == RATIO - 1));
    endtask

    task automatic check_idle(input string tag);
        chk(!out_valid && out_dm == 2'b11 && out_dq == 16'h0 && in_ready, tag,
            {out_valid, out_dm, out_dq, in_ready}, {1'b0, 2'b11, 16'h0, 1'b1});
    endtask

    initial begin
        int sent, out_w, out_b, cyc;
        checks = 0; errors = 0; done = 1'b0;
        rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_data = '0; in_be = '0;
        repeat (3) @(negedge clk);
        check_idle("R9 reset state");
        rst_n = 1'b1;
        sent = 0; out_w = 0; out_b = 0; cyc = 0;
        while (out_w < NWORDS) begin
            @(negedge clk);
            cyc++;
            if (out_w < sent) begin
                check_beat(out_w, out_b);
                if (out_b == RATIO - 1) begin
                    out_b = 0;
                    out_w++;
                end else begin
                    out_b++;
                end
            end else begin
                check_idle("R9 idle mask");
            end
            // Mostly continuous offers, some gaps, and one sparse stretch
            if (sent < NWORDS && (cyc % 11) != 7 &&
                !(sent >= 100 && sent < 110 && (cyc % 6) != 0)) begin
                in_valid = 1'b1;
                in_data  = gen_data(sent);
                in_be    = gen_be(sent);
                in_addr  = gen_addr(sent);
            end else begin
                in_valid = 1'b0;
            end
            if (in_valid && in_ready) sent++;
        end
        // Reset arriving mid-word drops the remaining beats
        in_valid = 1'b1;
        in_data = gen_data(7); in_be = gen_be(7); in_addr = gen_addr(7);
        @(negedge clk);
        in_valid = 1'b0;
        check_beat(7, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R9 reset mid-word");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R9 after reset");
        done = 1'b1;
    end
endmodule

// Top bench: runs both rate modes and applies the watchdog.
module ddr_wdata_adapter_bench;
    logic clk = 1'b0;
    int   chk_f, err_f, chk_h, err_h;
    logic done_f, done_h;

    always #10 clk = ~clk;

    ddr_wdata_adapter_drv #(.HALF(1'b0)) u_full (
        .clk(clk), .checks(chk_f), .errors(err_f), .done(done_f));
    ddr_wdata_adapter_drv #(.HALF(1'b1)) u_half (
        .clk(clk), .checks(chk_h), .errors(err_h), .done(done_h));

    initial begin
        int wd;
        int extra;
        wd = 0;
        extra = 0;
        while (!(done_f === 1'b1 && done_h === 1'b1) && wd < 100000) begin
            @(posedge clk);
            wd++;
        end
        if (wd >= 100000) begin
            extra = 1;
            $display("FAIL watchdog expired actual=%0d expected=<100000", wd);
        end
        $display("CHECKS %0d ERRORS %0d", chk_f + chk_h + extra, err_f + err_h + extra);
        $finish;
    end
endmodule